// File: doc/BRIEF.md
# Frame-Buffer Rectangle Transfer Engine

This block walks a rectangle of 16-bit pixels inside a 1024 x 512 frame buffer and produces one frame-buffer access per pixel. A transfer is started by a one-cycle `start` pulse. With it come a position word that gives the top-left corner, a size word that gives the width and height, and a direction flag. The host then offers 32-bit beats. Each beat covers two pixels, the low half first. The engine emits the x/y address of each pixel together with a write strobe (and masked write data) or a read strobe. It walks the pixels row by row, left to right. The frame-buffer storage and the host DMA logic sit outside the block.

The controller is a three-state machine.
- S_IDLE: no transfer. A start moves it to S_LOW.
- S_LOW: waiting for a beat. An accepted beat emits its low pixel and moves to S_HIGH, or to S_IDLE if that pixel was the last one. With no beat offered it stays in S_LOW and keeps its place in the rectangle.
- S_HIGH: emits the high pixel of the held beat. It then returns to S_LOW, or goes to S_IDLE after the last pixel.

A start in S_LOW or S_HIGH abandons the running transfer and reloads the engine.

Two mask controls shape writes. One forces bit 15 of every written pixel. The other suppresses the write when the destination pixel already has bit 15 set. That destination bit is supplied combinationally on `dst_msb`.

Top module: `rect_xfer_engine`

## Requirements
- R1: The first pixel address is x = `pos_word[9:0]` and y = `pos_word[24:16]`.
- R2: The width is ((`size_word[9:0]` - 1) mod 1024) + 1, so a field of 0 gives 1024 pixels per row.
- R3: The height is ((`size_word[24:16]` - 1) mod 512) + 1, so a field of 0 gives 512 rows.
- R4: A beat is taken only in S_LOW, where `beat_ready` is 1. Pixel `beat_data[15:0]` is accessed in the accepting cycle and pixel `beat_data[31:16]` in the next cycle. Pixels go left to right, then on to the next row.
- R5: While no beat is offered in S_LOW, no strobe is raised and the position in the rectangle is kept. The next beat resumes at the following pixel, even mid-row.
- R6: The row address advances modulo 512, and the column address (start x + offset) wraps modulo 1024.
- R7: On writes with `mask_ctl[0]` = 1, `fb_wdata[15]` is 1; bits 14:0 always equal the pixel.
- R8: On writes with `mask_ctl[1]` = 1 and `dst_msb` = 1, `fb_we` stays 0 for that pixel. The walk still advances.
- R9: A read transfer raises `fb_re` per pixel and never `fb_we`. `img_ready` is 1 from the cycle after a read start until the cycle after its last pixel.
- R10: The cycle after the last pixel of a write, `wr_done` pulses for one cycle and the engine returns to idle. The unused high half of a final beat is dropped.
- R11: A start while active restarts the engine with the new transfer and pulses `abort_err` for one cycle.
- R12: After reset the engine is idle, and `active`, `beat_ready`, `fb_we`, `fb_re`, `img_ready`, `wr_done` and `abort_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| start_rd | input | 1 | Direction of the new transfer, 1 = read |
| pos_word | input | 32 | Top-left position word |
| size_word | input | 32 | Width/height word |
| mask_ctl | input | 2 | Bit 0 forces bit 15 on writes; bit 1 protects pixels whose bit 15 is set |
| beat_valid | input | 1 | Host offers a beat |
| beat_data | input | 32 | Two pixels, low half first |
| beat_ready | output | 1 | Engine accepts a beat this cycle |
| fb_x | output | 10 | Pixel column address |
| fb_y | output | 9 | Pixel row address |
| fb_we | output | 1 | Write strobe |
| fb_re | output | 1 | Read strobe |
| fb_wdata | output | 16 | Write data after mask rules |
| dst_msb | input | 1 | Bit 15 of the addressed destination pixel |
| active | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read transfer in progress |
| wr_done | output | 1 | One-cycle pulse at write completion |
| abort_err | output | 1 | One-cycle pulse when a start abandons a transfer |

## Verification
The assertions assume the following about the inputs:
- `mask_ctl` holds steady for the duration of a transfer.
- `dst_msb` is valid in any cycle that carries a write strobe.
- `start` is a single-cycle pulse that is never raised in the same cycle as a beat.

The bench meets these by changing `mask_ctl` only between transfers. It drives `dst_msb` from `$urandom` at every pixel step. It drives `start` on its own falling edge and clears it one cycle later, before any beat is offered. Random rectangles are placed near the right and bottom edges so that both wraps occur, and directed cases cover zero size fields, an odd pixel count and an abort.

// File: rtl/rect_xfer_pkg.sv
package rect_xfer_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/rect_geom.sv
module rect_geom #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9,
    parameter int Y_LSB  = 16
) (
    input  logic [31:0]       pos,
    input  logic [31:0]       size,
    output logic [X_BITS-1:0] x0,
    output logic [Y_BITS-1:0] y0,
    output logic [X_BITS:0]   w,
    output logic [Y_BITS:0]   h
);
    logic [X_BITS-1:0] w_m1;
    logic [Y_BITS-1:0] h_m1;
    logic              unused_bits;

    always_comb begin
        x0   = pos[X_BITS-1:0];
        y0   = pos[Y_LSB +: Y_BITS];
        // a zero field wraps to the full extent
        w_m1 = size[X_BITS-1:0] - 1'b1;
        h_m1 = size[Y_LSB +: Y_BITS] - 1'b1;
        w    = {1'b0, w_m1} + (X_BITS+1)'(1);
        h    = {1'b0, h_m1} + (Y_BITS+1)'(1);
    end

    assign unused_bits = ^{pos, size};
endmodule

// File: rtl/rect_walker.sv
module rect_walker #(
    parameter int X_BITS = 10,
    parameter int Y_BITS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [X_BITS-1:0] x0,
    input  logic [Y_BITS-1:0] y0,
    input  logic [X_BITS:0]   w,
    input  logic [Y_BITS:0]   h,
    input  logic              step,
    output logic [X_BITS-1:0] x,
    output logic [Y_BITS-1:0] y,
    output logic              last
);
    logic [X_BITS-1:0] x0_q, col_q;
    logic [X_BITS:0]   w_q;
    logic [Y_BITS-1:0] row_q;
    logic [Y_BITS:0]   rows_q;
    logic              row_end;

    assign row_end = ({1'b0, col_q} == (w_q - 1'b1));
    assign last    = row_end && (rows_q == (Y_BITS+1)'(1));
    assign x       = x0_q + col_q;
    assign y       = row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x0_q   <= '0;
            col_q  <= '0;
            w_q    <= (X_BITS+1)'(1);
            row_q  <= '0;
            rows_q <= '0;
        end else if (load) begin
            x0_q   <= x0;
            col_q  <= '0;
            w_q    <= w;
            row_q  <= y0;
            rows_q <= h;
        end else if (step) begin
            if (row_end) begin
                col_q  <= '0;
                row_q  <= row_q + 1'b1;
                rows_q <= rows_q - 1'b1;
            end else begin
                col_q  <= col_q + 1'b1;
            end
        end
    end

    // R6
    col_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rows_q != '0) |-> ({1'b0, col_q} < w_q));

    // R6
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && row_end && !last) |=> (row_q == $past(row_q) + 1'b1));
endmodule

// File: rtl/pixel_mask.sv
module pixel_mask #(
    parameter int PIX_BITS = 16
) (
    input  logic                we_req,
    input  logic [PIX_BITS-1:0] pix,
    input  logic                force_msb,
    input  logic                keep_set,
    input  logic                dst_msb,
    output logic                we,
    output logic [PIX_BITS-1:0] wdata
);
    always_comb begin
        wdata = pix;
        if (force_msb)
            wdata[PIX_BITS-1] = 1'b1;
        we = we_req && !(keep_set && dst_msb);
    end

    // R7
    force_msb_chk: assert property (@(posedge we_req)
        force_msb |-> wdata[PIX_BITS-1]);
endmodule

// File: rtl/rect_xfer_engine.sv
module rect_xfer_engine
    import rect_xfer_pkg::*;
#(
    parameter int X_BITS   = 10,
    parameter int Y_BITS   = 9,
    parameter int PIX_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_rd,
    input  logic [31:0]         pos_word,
    input  logic [31:0]         size_word,
    input  logic [1:0]          mask_ctl,
    input  logic                beat_valid,
    input  logic [31:0]         beat_data,
    output logic                beat_ready,
    output logic [X_BITS-1:0]   fb_x,
    output logic [Y_BITS-1:0]   fb_y,
    output logic                fb_we,
    output logic                fb_re,
    output logic [PIX_BITS-1:0] fb_wdata,
    input  logic                dst_msb,
    output logic                active,
    output logic                img_ready,
    output logic                wr_done,
    output logic                abort_err
);
    localparam int BEAT_BITS = 2 * PIX_BITS;

    xfer_state_e         state_q, state_d;
    logic [X_BITS-1:0]   g_x0;
    logic [Y_BITS-1:0]   g_y0;
    logic [X_BITS:0]     g_w;
    logic [Y_BITS:0]     g_h;
    logic                last_pix;
    logic                fire;
    logic                is_rd_q;
    logic [PIX_BITS-1:0] hi_q, cur_pix;

    rect_geom #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .Y_LSB(16)) u_geom (
        .pos(pos_word), .size(size_word),
        .x0(g_x0), .y0(g_y0), .w(g_w), .h(g_h)
    );

    rect_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(start),
        .x0(g_x0), .y0(g_y0), .w(g_w), .h(g_h),
        .step(fire), .x(fb_x), .y(fb_y), .last(last_pix)
    );

    pixel_mask #(.PIX_BITS(PIX_BITS)) u_mask (
        .we_req(fire && !is_rd_q), .pix(cur_pix),
        .force_msb(mask_ctl[0]), .keep_set(mask_ctl[1]), .dst_msb(dst_msb),
        .we(fb_we), .wdata(fb_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LOW;
            S_LOW: begin
                if (start)           state_d = S_LOW;
                else if (beat_valid) state_d = last_pix ? S_IDLE : S_HIGH;
            end
            S_HIGH: begin
                if (start) state_d = S_LOW;
                else       state_d = last_pix ? S_IDLE : S_LOW;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        beat_ready = 1'b0;
        fire       = 1'b0;
        cur_pix    = hi_q;
        unique case (state_q)
            S_IDLE: ;
            S_LOW: begin
                beat_ready = !start;
                fire       = beat_valid && !start;
                cur_pix    = beat_data[PIX_BITS-1:0];
            end
            S_HIGH: fire = !start;
            default: ;
        endcase
        active = (state_q != S_IDLE);
        fb_re  = fire && is_rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_rd_q   <= 1'b0;
            hi_q      <= '0;
            img_ready <= 1'b0;
            wr_done   <= 1'b0;
            abort_err <= 1'b0;
        end else begin
            wr_done   <= fire && last_pix && !is_rd_q;
            abort_err <= start && (state_q != S_IDLE);
            if (state_q == S_LOW && beat_valid)
                hi_q <= beat_data[BEAT_BITS-1:PIX_BITS];
            if (start) begin
                is_rd_q   <= start_rd;
                img_ready <= start_rd;
            end else if (fire && last_pix) begin
                img_ready <= 1'b0;
            end
        end
    end

    // R9
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fb_we && fb_re));

    // R9
    img_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        img_ready |-> active);

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_ctl[1] && dst_msb) |-> !fb_we);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R11
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> $past(start));

    // R4
    ready_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_ready |-> active);
endmodule

// File: tb/test_rect_xfer_engine.sv
`timescale 1ns/1ps
module test_rect_xfer_engine;
    logic        clk = 0, rst_n = 0;
    logic        start = 0, start_rd = 0;
    logic [31:0] pos_word = 0, size_word = 0, beat_data = 0;
    logic [1:0]  mask_ctl = 0;
    logic        beat_valid = 0, dst_msb = 0;
    logic        beat_ready, fb_we, fb_re, active, img_ready, wr_done, abort_err;
    logic [9:0]  fb_x;
    logic [8:0]  fb_y;
    logic [15:0] fb_wdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench model of the running transfer
    int       m_x0, m_col, m_w, m_left, m_row;
    bit       m_rd;
    bit [1:0] m_mask;

    rect_xfer_engine i_rect_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
        .pos_word(pos_word), .size_word(size_word), .mask_ctl(mask_ctl),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_ready(beat_ready),
        .fb_x(fb_x), .fb_y(fb_y), .fb_we(fb_we), .fb_re(fb_re),
        .fb_wdata(fb_wdata), .dst_msb(dst_msb), .active(active),
        .img_ready(img_ready), .wr_done(wr_done), .abort_err(abort_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int dec_w(input logic [31:0] s);
        return ((int'(s[9:0]) - 1) & 32'h3FF) + 1;
    endfunction

    function automatic int dec_h(input logic [31:0] s);
        return ((int'(s[24:16]) - 1) & 32'h1FF) + 1;
    endfunction

    task automatic do_start(input logic [31:0] p, input logic [31:0] s,
                            input bit rd, input bit [1:0] mk, input bit expect_abort);
        @(negedge clk);
        start = 1; start_rd = rd; pos_word = p; size_word = s; mask_ctl = mk;
        m_x0 = int'(p[9:0]); m_row = int'(p[24:16]); m_col = 0;
        m_w = dec_w(s); m_left = dec_w(s) * dec_h(s);
        m_rd = rd; m_mask = mk;
        @(negedge clk);
        start = 0; #1;
        chk(active == 1, "R4 active after start", active, 1);
        chk(beat_ready == 1, "R4 ready in S_LOW", beat_ready, 1);
        chk(img_ready == rd, "R9 img_ready on start", img_ready, rd);
        chk(abort_err == expect_abort, "R11 abort pulse", abort_err, expect_abort);
    endtask

    task automatic check_pix(input logic [15:0] pix);
        int  ex;
        bit  we_exp;
        logic [15:0] wd;
        ex = (m_x0 + m_col) & 32'h3FF;
        chk(fb_x == ex[9:0], "R1 R6 column address", fb_x, ex);
        chk(fb_y == m_row[8:0], "R1 R6 row address", fb_y, m_row & 32'h1FF);
        if (m_rd) begin
            chk(fb_re == 1 && fb_we == 0, "R9 read strobe", {fb_re, fb_we}, 2'b10);
        end else begin
            we_exp = !(m_mask[1] && dst_msb);
            wd = pix | (m_mask[0] ? 16'h8000 : 16'h0);
            chk(fb_re == 0 && fb_we == we_exp, "R8 write strobe", {fb_re, fb_we}, {1'b0, we_exp});
            if (we_exp) chk(fb_wdata == wd, "R7 write data", fb_wdata, wd);
        end
        if (m_col == m_w - 1) begin
            m_col = 0;
            m_row = (m_row + 1) & 32'h1FF;
        end else begin
            m_col++;
        end
        m_left--;
    endtask

    task automatic check_done();
        chk(active == 0, "R10 idle after last", active, 0);
        chk(img_ready == 0, "R9 img_ready cleared", img_ready, 0);
        chk(wr_done == !m_rd, "R10 done pulse", wr_done, !m_rd);
        @(negedge clk); #1;
        chk(wr_done == 0, "R10 single pulse", wr_done, 0);
    endtask

    task automatic send_word(input logic [31:0] d);
        @(negedge clk);
        beat_valid = 1; beat_data = d; dst_msb = 1'($urandom);
        #1;
        chk(beat_ready == 1, "R4 beat accepted", beat_ready, 1);
        check_pix(d[15:0]);
        @(negedge clk);
        beat_valid = 0; dst_msb = 1'($urandom);
        #1;
        if (m_left == 0) begin
            check_done();
        end else begin
            check_pix(d[31:16]);
            if (m_left == 0) begin
                @(negedge clk); #1;
                check_done();
            end
        end
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk(fb_we == 0 && fb_re == 0, "R5 no strobe in pause", {fb_we, fb_re}, 0);
        end
    endtask

    task automatic run_all(input bit with_pause);
        while (m_left > 0) begin
            send_word($urandom);
            if (with_pause && m_left > 0 && ($urandom % 3 == 0)) pause(1 + $urandom % 3);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(active == 0 && beat_ready == 0, "R12 reset idle", {active, beat_ready}, 0);
        chk(fb_we == 0 && fb_re == 0, "R12 reset strobes", {fb_we, fb_re}, 0);
        chk(img_ready == 0 && wr_done == 0 && abort_err == 0, "R12 reset flags",
            {img_ready, wr_done, abort_err}, 0);
        @(negedge clk); rst_n = 1;

        // R2: zero width field gives 1024 columns, starting near the right edge
        do_start({7'd0, 9'd3, 6'd0, 10'd1000}, {7'd0, 9'd1, 16'd0}, 0, 2'b00, 0);
        run_all(0);

        // R3: zero height field gives 512 rows, wrapping past row 511
        do_start({7'd0, 9'd300, 6'd0, 10'd7}, {7'd0, 9'd0, 16'd1}, 1, 2'b00, 0);
        run_all(0);

        // R10: odd count, high half of the final beat dropped
        do_start({7'd0, 9'd511, 6'd0, 10'd1022}, {7'd0, 9'd1, 16'd3}, 0, 2'b01, 0);
        run_all(0);

        // R5: mid-row pause, resume at the following pixel
        do_start({7'd0, 9'd10, 6'd0, 10'd20}, {7'd0, 9'd2, 16'd5}, 0, 2'b10, 0);
        send_word(32'h1111_2222);
        pause(4);
        run_all(1);

        // R11: abort a write with a read
        do_start({7'd0, 9'd1, 6'd0, 10'd1}, {7'd0, 9'd2, 16'd4}, 0, 2'b00, 0);
        send_word(32'hAAAA_5555);
        do_start({7'd0, 9'd2, 6'd0, 10'd2}, {7'd0, 9'd2, 16'd3}, 1, 2'b00, 1);
        run_all(0);

        // random transfers near both edges
        for (int t = 0; t < 25; t++) begin
            logic [31:0] p, s;
            p = {7'd0, 9'(500 + $urandom % 12), 6'd0, 10'(1015 + $urandom % 9)};
            s = {7'd0, 9'(1 + $urandom % 4), 6'd0, 10'(1 + $urandom % 7)};
            do_start(p, s, 1'($urandom), 2'($urandom), 0);
            run_all(1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule